// File: doc/BRIEF.md
# Multi-Port Receive Cell Responder

This block is the cell source on the receive side of a shared byte-wide cell bus. Several ports sit behind one data bus and one start-of-cell line, and each port also has its own cell-available status line. Status is reported directly per port. Cells reach each port through a byte-serial load interface and are held in a small buffer per port. A downstream bus master polls the status lines, places a port address on the bus, and then asserts read enable. The addressed port answers on the next clock with the first byte of its oldest buffered cell, with start-of-cell high for that byte.

Each port keeps its own read position. The master can pause a cell by dropping enable, or can address another port in the middle of a cell, and the interrupted cell later resumes at the byte where it stopped. The shared bus is never tri-stated. A valid flag marks the cycles in which a port drives it, and the data lines are held at zero at all other times. A cell that arrives for a port whose buffer is full is dropped whole, and a sticky overflow flag is raised for that port.

Top module: `cell_rx_responder`

## Requirements
- R1: Port k (counting from 0) answers only to read address k. With enable high and an address of NUM_PORTS or above, the bus stays idle and no port's state changes.
- R2: cellAvail[k] is high exactly when port k holds at least one fully loaded cell whose transfer has not yet begun. A cell counts as fully loaded once CELL_BYTES bytes have been written to that port.
- R3: cellAvail[k] falls on the clock edge at which port k starts sending its last waiting cell, even though the rest of that cell is still being read out.
- R4: If rdEn is sampled high at a clock edge with the address of a port that has a cell ready or in progress, rxValid is high after that edge with that port's next byte on rxData.
- R5: rxSoc is high together with the first byte of each cell only, and is never high for any other byte.
- R6: A port sends its cells in the order they were loaded, and the bytes of each cell in the order they were written. After the last byte of a cell, the next transfer from that port starts a new cell.
- R7: Dropping rdEn, or addressing another port, in the middle of a cell pauses that cell. The cell resumes at the next unsent byte, with rxSoc low, the next time its port is addressed with enable high.
- R8: rxValid is low and rxData is zero after any edge where rdEn was low, or where the addressed port had nothing to send.
- R9: Each port holds at most DEPTH cells, and the cell being read still occupies its slot. A cell whose first byte arrives while the port is full is discarded in full, and overflow[k] goes high and stays high until reset.
- R10: Loads, reads and overflow on one port leave every other port's buffer, status and overflow flag unchanged.
- R11: During reset, rxValid, rxSoc, rxData, every cellAvail bit and every overflow bit are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Load strobe: one cell byte per cycle |
| wrPort | input | PORT_W (clog2 NUM_PORTS) | Port the load byte belongs to |
| wrData | input | DATA_W | Load byte |
| rdEn | input | 1 | Read enable from the bus master |
| rdAddr | input | ADDR_W | Port address from the bus master |
| rxData | output | DATA_W | Shared cell data bus, zero when not driven |
| rxSoc | output | 1 | Start of cell, high with the first byte |
| rxValid | output | 1 | Some port drives rxData this cycle |
| cellAvail | output | NUM_PORTS | Per-port whole-cell-ready status |
| overflow | output | NUM_PORTS | Per-port sticky dropped-cell flag |

## Verification
The bench builds the block with four ports, six-byte cells and a two-cell buffer per port. With cells this short, a wrap of the read position, a full buffer, a rejected cell and the slot freed at the end of a read are each only a few cycles apart. Directed phases load and drain single ports, fill a port past its capacity, pause and interleave two ports mid-cell, and probe addresses above the last port. A long mixed phase then loads and reads all four ports together, so that loads finish on the same edges as cell starts and cell ends.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;

  // Fixed carrier widths for the control-to-datapath strobes; the
  // datapath slices the low bits it needs.
  localparam int LOC_W  = 12;
  localparam int PIDX_W = 4;

  typedef struct packed {
    logic              wrStb;
    logic [PIDX_W-1:0] wrPort;
    logic [LOC_W-1:0]  wrLoc;
    logic              rdStb;
    logic [PIDX_W-1:0] rdPort;
    logic [LOC_W-1:0]  rdLoc;
    logic              rdSoc;
  } strobe_t;

endpackage

// File: rtl/cell_rx_ctrl.sv
module cell_rx_ctrl
  import cell_rx_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int CELL_BYTES = 53,
  parameter int DEPTH      = 2,
  parameter int ADDR_W     = 5,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [PORT_W-1:0]    wrPort,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output strobe_t              strb,
  output logic [NUM_PORTS-1:0] cellAvail,
  output logic [NUM_PORTS-1:0] overflow
);

  localparam int OFF_W  = $clog2(CELL_BYTES);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [OFF_W-1:0]  LAST_OFF  = OFF_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);

  // Per-port state
  logic [OFF_W-1:0]  wrOff   [NUM_PORTS];
  logic [SLOT_W-1:0] wrSlot  [NUM_PORTS];
  logic [OFF_W-1:0]  rdOff   [NUM_PORTS];
  logic [SLOT_W-1:0] rdSlot  [NUM_PORTS];
  logic [CNT_W-1:0]  queued  [NUM_PORTS];  // complete, not yet started
  logic [CNT_W-1:0]  used    [NUM_PORTS];  // slots held, incl. cell in read
  logic [NUM_PORTS-1:0] dropping;
  logic [NUM_PORTS-1:0] ovfReg;

  // Per-port decisions for the coming edge
  logic [NUM_PORTS-1:0] wrThis, firstByte, accept, reject, startAcc, cellDone;
  logic [NUM_PORTS-1:0] rdGo, rdStart, rdEnd;

  always_comb begin
    strb = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      wrThis[p]    = wrValid && (wrPort == PORT_W'(p));
      firstByte[p] = (wrOff[p] == '0);
      reject[p]    = wrThis[p] && firstByte[p] && (used[p] >= FULL_CNT);
      accept[p]    = wrThis[p] && (firstByte[p] ? (used[p] < FULL_CNT) : !dropping[p]);
      startAcc[p]  = accept[p] && firstByte[p];
      cellDone[p]  = accept[p] && (wrOff[p] == LAST_OFF);
      rdGo[p]      = rdEn && (rdAddr == ADDR_W'(p)) &&
                     ((rdOff[p] != '0) || (queued[p] != '0));
      rdStart[p]   = rdGo[p] && (rdOff[p] == '0);
      rdEnd[p]     = rdGo[p] && (rdOff[p] == LAST_OFF);
      if (accept[p]) begin
        strb.wrStb  = 1'b1;
        strb.wrPort = PIDX_W'(p);
        strb.wrLoc  = LOC_W'(int'(wrSlot[p]) * CELL_BYTES + int'(wrOff[p]));
      end
      if (rdGo[p]) begin
        strb.rdStb  = 1'b1;
        strb.rdPort = PIDX_W'(p);
        strb.rdLoc  = LOC_W'(int'(rdSlot[p]) * CELL_BYTES + int'(rdOff[p]));
        strb.rdSoc  = (rdOff[p] == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        wrOff[p]  <= '0;
        wrSlot[p] <= '0;
        rdOff[p]  <= '0;
        rdSlot[p] <= '0;
        queued[p] <= '0;
        used[p]   <= '0;
      end
      dropping <= '0;
      ovfReg   <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wrThis[p]) begin
          wrOff[p] <= (wrOff[p] == LAST_OFF) ? '0 : wrOff[p] + 1'b1;
          if (firstByte[p]) dropping[p] <= reject[p];
          if (reject[p]) ovfReg[p] <= 1'b1;
        end
        if (cellDone[p])
          wrSlot[p] <= (wrSlot[p] == LAST_SLOT) ? '0 : wrSlot[p] + 1'b1;
        if (rdGo[p]) begin
          rdOff[p] <= rdEnd[p] ? '0 : rdOff[p] + 1'b1;
          if (rdEnd[p])
            rdSlot[p] <= (rdSlot[p] == LAST_SLOT) ? '0 : rdSlot[p] + 1'b1;
        end
        queued[p] <= queued[p] + CNT_W'(cellDone[p]) - CNT_W'(rdStart[p]);
        used[p]   <= used[p] + CNT_W'(startAcc[p]) - CNT_W'(rdEnd[p]);
      end
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gStatus
    assign cellAvail[g] = (queued[g] != '0);
    assign overflow[g]  = ovfReg[g];

    // R9: occupancy never exceeds the buffer, waiting cells fit inside it
    p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
      (used[g] <= FULL_CNT) && (queued[g] <= used[g]));

    // R9: overflow is sticky until reset
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
      overflow[g] |=> overflow[g]);

    // R2: a port only becomes available after a load byte for it
    p_avail_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cellAvail[g]) |-> $past(wrValid && (wrPort == PORT_W'(g))));

    // R3: availability only drops when this port was read
    p_avail_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
      $fell(cellAvail[g]) |-> $past(rdEn && (rdAddr == ADDR_W'(g))));
  end

endmodule

// File: rtl/cell_rx_dpath.sv
module cell_rx_dpath
  import cell_rx_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int CELL_BYTES = 53,
  parameter int DEPTH      = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxSoc,
  output logic              rxValid
);

  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int BUF_BYTES = DEPTH * CELL_BYTES;
  localparam int BUF_W     = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

  logic [DATA_W-1:0] cellMem [NUM_PORTS][BUF_BYTES];

  logic [PORT_W-1:0] wrPortIdx, rdPortIdx;
  logic [BUF_W-1:0]  wrLocIdx, rdLocIdx;
  logic              unusedHighBits;

  assign wrPortIdx = strb.wrPort[PORT_W-1:0];
  assign rdPortIdx = strb.rdPort[PORT_W-1:0];
  assign wrLocIdx  = strb.wrLoc[BUF_W-1:0];
  assign rdLocIdx  = strb.rdLoc[BUF_W-1:0];
  assign unusedHighBits = ^{strb.wrPort[PIDX_W-1:PORT_W], strb.rdPort[PIDX_W-1:PORT_W],
                            strb.wrLoc[LOC_W-1:BUF_W], strb.rdLoc[LOC_W-1:BUF_W]};

  always_ff @(posedge clk) begin
    if (strb.wrStb) cellMem[wrPortIdx][wrLocIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxSoc   <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= strb.rdStb;
      rxSoc   <= strb.rdStb && strb.rdSoc;
      rxData  <= strb.rdStb ? cellMem[rdPortIdx][rdLocIdx] : '0;
    end
  end

  // R6: a byte is never loaded into the location being sent in the same cycle
  p_no_rw_collision_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.rdStb) |-> !((wrPortIdx == rdPortIdx) && (wrLocIdx == rdLocIdx)));

endmodule

// File: rtl/cell_rx_responder.sv
module cell_rx_responder
  import cell_rx_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int CELL_BYTES = 53,
  parameter int DEPTH      = 2,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [PORT_W-1:0]    wrPort,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rxData,
  output logic                 rxSoc,
  output logic                 rxValid,
  output logic [NUM_PORTS-1:0] cellAvail,
  output logic [NUM_PORTS-1:0] overflow
);

  strobe_t strb;

  cell_rx_ctrl #(
    .NUM_PORTS(NUM_PORTS), .CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrPort(wrPort),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb),
    .cellAvail(cellAvail), .overflow(overflow)
  );

  cell_rx_dpath #(
    .NUM_PORTS(NUM_PORTS), .CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rxData(rxData), .rxSoc(rxSoc), .rxValid(rxValid)
  );

  // R4: the bus is driven only after an edge that sampled enable
  p_valid_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(rdEn));

  // R1: addresses above the last port never produce a byte
  p_valid_addr_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ($past(rdAddr) < ADDR_W'(NUM_PORTS)));

  // R8: an idle bus carries zero
  p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> (!rxValid && !rxSoc && (rxData == '0)));

endmodule

// File: tb/sim_cell_rx_responder.sv
module sim_cell_rx_responder;

  localparam int NP = 4;
  localparam int CB = 6;
  localparam int DP = 2;

  // 8-unit period: 125 MHz with 1 ns time units
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic          wrValid = 1'b0;
  logic [1:0]    wrPort = '0;
  logic [7:0]    wrData = '0;
  logic          rdEn = 1'b0;
  logic [4:0]    rdAddr = '0;
  logic [7:0]    rxData;
  logic          rxSoc, rxValid;
  logic [NP-1:0] cellAvail, overflow;

  cell_rx_responder #(.NUM_PORTS(NP), .CELL_BYTES(CB), .DEPTH(DP)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrPort(wrPort), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rxData(rxData), .rxSoc(rxSoc), .rxValid(rxValid),
    .cellAvail(cellAvail), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference: byte queues per port
  logic [7:0] pendQ [NP][$];   // complete cells waiting, bytes in order
  logic [7:0] curQ  [NP][$];   // rest of the cell being sent
  logic [7:0] wrBuf [NP][$];   // cell being loaded
  int         wrCnt [NP];
  bit         drop  [NP];
  int         slots [NP];
  bit         ovfM  [NP];
  logic       expValid, expSoc;
  logic [7:0] expData;
  logic [7:0] dataCtr = 8'h01;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [NP-1:0] ea, eo;
    for (int p = 0; p < NP; p++) begin
      ea[p] = (pendQ[p].size() >= CB);
      eo[p] = ovfM[p];
    end
    check(rxValid == expValid, "R4 R8 rxValid", rxValid, expValid);
    check(rxSoc == expSoc, "R5 R7 rxSoc", rxSoc, expSoc);
    check(rxData == expData, "R6 R8 rxData", rxData, expData);
    check(cellAvail == ea, "R2 R3 R10 cellAvail", cellAvail, ea);
    check(overflow == eo, "R9 R10 overflow", overflow, eo);
  endtask

  // One clock: drive at negedge, predict the edge, compare at next negedge
  task automatic cyc(input bit wv, input int wp, input bit re, input int ra);
    int used0 [NP];
    logic [7:0] d;
    d = dataCtr;
    wrValid = wv; wrPort = wp[1:0]; wrData = d;
    rdEn = re; rdAddr = ra[4:0];
    if (wv) dataCtr = dataCtr + 8'd1;
    for (int p = 0; p < NP; p++) used0[p] = slots[p];
    expValid = 1'b0; expSoc = 1'b0; expData = 8'h00;
    if (re && ra < NP) begin
      if (curQ[ra].size() > 0) begin
        expData = curQ[ra].pop_front(); expValid = 1'b1;
      end else if (pendQ[ra].size() >= CB) begin
        for (int i = 0; i < CB; i++) curQ[ra].push_back(pendQ[ra].pop_front());
        expData = curQ[ra].pop_front(); expValid = 1'b1; expSoc = 1'b1;
      end
      if (expValid && curQ[ra].size() == 0) slots[ra]--;
    end
    if (wv) begin
      if (wrCnt[wp] == 0) begin
        if (used0[wp] < DP) begin drop[wp] = 1'b0; slots[wp]++; end
        else begin drop[wp] = 1'b1; ovfM[wp] = 1'b1; end
      end
      if (!drop[wp]) wrBuf[wp].push_back(d);
      wrCnt[wp]++;
      if (wrCnt[wp] == CB) begin
        wrCnt[wp] = 0;
        if (!drop[wp]) foreach (wrBuf[wp][i]) pendQ[wp].push_back(wrBuf[wp][i]);
        wrBuf[wp].delete();
      end
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic loadCell(input int p);
    for (int i = 0; i < CB; i++) cyc(1'b1, p, 1'b0, 0);
  endtask

  task automatic readFor(input int a, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b1, a);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      wrCnt[p] = 0; drop[p] = 1'b0; slots[p] = 0; ovfM[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R11: everything quiet while in reset
    check(rxValid == 1'b0, "R11 rxValid in reset", rxValid, 0);
    check(rxSoc == 1'b0, "R11 rxSoc in reset", rxSoc, 0);
    check(rxData == 8'h00, "R11 rxData in reset", rxData, 0);
    check(cellAvail == '0, "R11 cellAvail in reset", cellAvail, 0);
    check(overflow == '0, "R11 overflow in reset", overflow, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R4 R5 R6: one cell on port 0, read straight through and past its end
    loadCell(0);
    readFor(0, CB + 2);

    // R9 R10: three cells to port 1, the third is discarded
    loadCell(1); loadCell(1); loadCell(1);
    // R1 R8: enable with out-of-range addresses and with an empty port
    readFor(4, 3); readFor(31, 2); readFor(2, 2);
    cyc(1'b0, 0, 1'b0, 1);

    // R7: pause mid-cell, switch to port 2 mid-cell, come back
    loadCell(2);
    readFor(1, 3);
    cyc(1'b0, 0, 1'b0, 1); cyc(1'b0, 0, 1'b0, 1);
    readFor(2, 2);
    readFor(1, 2);
    readFor(2, CB);
    readFor(1, CB + 3);

    // R9: once a slot frees, a new cell on port 1 is taken again
    loadCell(1);
    readFor(1, CB + 1);

    // R3: port 3 availability falls at cell start while loads continue
    loadCell(3);
    for (int i = 0; i < CB; i++) cyc(1'b1, 3, 1'b1, 3);
    readFor(3, CB + 1);

    // R1 R2 R3 R5 R6 R7 R9 R10: mixed traffic on all ports
    for (int i = 0; i < 3000; i++) begin
      bit wv, re;
      int wp, ra;
      wv = ($urandom % 3) != 0;
      wp = $urandom % NP;
      re = ($urandom % 4) != 0;
      ra = (($urandom % 10) == 0) ? 4 + ($urandom % 28) : ($urandom % NP);
      cyc(wv, wp, re, ra);
    end
    for (int p = 0; p < NP; p++) readFor(p, 3 * CB);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule